// File: doc/BRIEF.md
# Four-Way Thread Issue Picker

This block chooses, in every clock cycle, which one of four hardware threads may issue an instruction into a single-issue, in-order pipeline that all four threads share. The same choice steers instruction fetch, so the thread that issues is also the thread that fetches. The choice is combinational from registered per-thread state and the current-cycle inputs. A different thread can therefore be chosen on every cycle, and switching threads costs no cycles.

Each thread owns a small state machine with four states: TS_RUN (able to issue), TS_LLWAIT (waiting for a long-latency operation to finish), TS_SPEC (a load-dependent instruction was issued before its load result was known) and TS_MISSWAIT (that load missed, the dependent instruction was squashed, and the thread waits for the cache fill). The transitions are as follows. In TS_RUN, when the thread is granted, a long-latency hint goes to TS_LLWAIT, otherwise a load-dependent hint goes to TS_SPEC, otherwise the thread stays in TS_RUN. TS_LLWAIT returns to TS_RUN on a done pulse. TS_SPEC returns to TS_RUN on a load hit and goes to TS_MISSWAIT on a load miss. TS_MISSWAIT returns to TS_RUN on a fill pulse.

A thread in TS_RUN with its ready flag set is a candidate. A candidate without the load-dependent hint is a normal candidate, and one with the hint is a speculative candidate. Arbitration uses a four-entry recency list. Normal candidates are served first and speculative candidates after them. Within each class, the thread that was granted longest ago wins.

Top module: `thread_picker`

## Requirements
- R1: `issue_gnt` has at most one bit set in any cycle, and it is all zero exactly when `idle` is high.
- R2: Whenever at least one candidate exists, some thread is granted in that same cycle. Consecutive cycles may grant different threads with no empty cycle in between.
- R3: Within one class, the grant goes to the candidate that was granted least recently. A granted thread becomes the most recent. After reset the recency order is thread 0 (oldest), then 1, 2 and 3, so with all four ready and no hints the grants run 0, 1, 2, 3, 0, …
- R4: `fetch_tid` is the binary index of the granted thread in the same cycle, and 0 when idle.
- R5: A thread granted with its `ll_hint` bit set issues nothing from the next cycle on, until the cycle after a pulse on its `ll_done` bit.
- R6: A thread granted with its `dep_hint` bit set (and `ll_hint` clear) issues nothing until its load result arrives (`ld_vld` bit high). On a hit (`ld_hit` bit high) no squash is raised, and the thread is a candidate again from the next cycle.
- R7: On a miss (`ld_vld` bit high and `ld_hit` bit low) for a thread in TS_SPEC, that thread's `squash` bit is high in that same cycle. The thread then issues nothing until the cycle after a pulse on its `fill_done` bit.
- R8: A speculative candidate is granted only when no normal candidate exists.
- R9: With no candidate, `idle` is high and no grant is driven. This is also the state right after reset when no ready flag is set.
- R10: `ll_done`, `ld_vld`/`ld_hit` and `fill_done` pulses for a thread that is not in the state waiting for them have no effect on grants or squashes.
- R11: When a granted thread has both `ll_hint` and `dep_hint` set, it waits for `ll_done`, and a later load result for it raises no squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | 4 | Per-thread: an instruction is available to issue |
| ll_hint | input | 4 | Per-thread: the next instruction is long-latency |
| dep_hint | input | 4 | Per-thread: the next instruction depends on an outstanding load |
| ll_done | input | 4 | Per-thread pulse: the long-latency operation has finished |
| ld_vld | input | 4 | Per-thread: a load result is present this cycle |
| ld_hit | input | 4 | Per-thread: that load hit (meaningful with `ld_vld`) |
| fill_done | input | 4 | Per-thread pulse: the fill of a missed load has finished |
| issue_gnt | output | 4 | One-hot issue grant |
| fetch_tid | output | 2 | Binary index of the thread to fetch from |
| squash | output | 4 | Per-thread: kill the speculatively issued dependent instruction |
| idle | output | 1 | No thread can issue this cycle |

## Verification
A corrupted recency list first shows up at the ports as a grant to the wrong thread. This happens on the very next cycle in which two or more candidates of the same class compete. Until that happens, the fault stays hidden. A thread state machine stuck in a wait state shows up as a ready thread that is never granted, or as a missing `squash` bit in the cycle its load result arrives. A state machine that leaves a wait state too early shows up as a grant during a cycle in which the thread should still be blocked. The bench runs a cycle-exact model beside the design, through directed phases and a long pseudo-random sweep, so each of these faults turns into a mismatch within a few cycles of the stimulus that exposes it.

// File: rtl/tpick_pkg.sv
package tpick_pkg;
    typedef enum logic [1:0] {
        TS_RUN      = 2'd0,
        TS_LLWAIT   = 2'd1,
        TS_SPEC     = 2'd2,
        TS_MISSWAIT = 2'd3
    } tstate_e;
endpackage

// File: rtl/tpick_thread.sv
module tpick_thread
    import tpick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic ll_i,
    input  logic dep_i,
    input  logic gnt_i,
    input  logic ll_done_i,
    input  logic ld_vld_i,
    input  logic ld_hit_i,
    input  logic fill_i,
    output logic elig_norm_o,
    output logic elig_spec_o,
    output logic squash_o
);
    tstate_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_RUN: begin
                if (gnt_i) begin
                    if (ll_i)       st_d = TS_LLWAIT;
                    else if (dep_i) st_d = TS_SPEC;
                end
            end
            TS_LLWAIT:   if (ll_done_i) st_d = TS_RUN;
            TS_SPEC:     if (ld_vld_i)  st_d = ld_hit_i ? TS_RUN : TS_MISSWAIT;
            TS_MISSWAIT: if (fill_i)    st_d = TS_RUN;
            default:     st_d = TS_RUN;
        endcase
    end

    always_comb begin
        elig_norm_o = 1'b0;
        elig_spec_o = 1'b0;
        squash_o    = 1'b0;
        unique case (st_q)
            TS_RUN: begin
                elig_norm_o = ready_i & ~dep_i;
                elig_spec_o = ready_i & dep_i;
            end
            TS_SPEC:     squash_o = ld_vld_i & ~ld_hit_i;
            TS_LLWAIT:   ;
            TS_MISSWAIT: ;
            default:     ;
        endcase
    end

    a_r5_ll_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_LLWAIT) |-> !gnt_i);
    a_r6_spec_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_SPEC) |-> !gnt_i);
    a_r6_hit_no_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_i && ld_hit_i) |-> !squash_o);
    a_r7_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_MISSWAIT) |-> !gnt_i);
    a_r7_squash_leads_wait: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> (st_q == TS_MISSWAIT));
endmodule

// File: rtl/tpick_lru.sv
module tpick_lru #(
    parameter int NT = 4,
    localparam int IW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] req_hi,
    input  logic [NT-1:0] req_lo,
    output logic [NT-1:0] gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    logic [IW-1:0] order_q [NT];
    logic [IW-1:0] order_d [NT];
    logic          hit_hi, hit_lo;
    logic [IW-1:0] idx_hi, idx_lo;
    logic [IW-1:0] pos;

    // oldest entry sits at index 0; scan downward so the oldest hit wins
    always_comb begin
        hit_hi = 1'b0;
        hit_lo = 1'b0;
        idx_hi = '0;
        idx_lo = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (req_hi[order_q[i]]) begin
                hit_hi = 1'b1;
                idx_hi = order_q[i];
            end
            if (req_lo[order_q[i]]) begin
                hit_lo = 1'b1;
                idx_lo = order_q[i];
            end
        end
        any     = hit_hi | hit_lo;
        gnt_idx = hit_hi ? idx_hi : (hit_lo ? idx_lo : '0);
        gnt     = any ? (NT'(1) << gnt_idx) : '0;
    end

    always_comb begin
        pos = '0;
        for (int i = 0; i < NT; i++) begin
            if (order_q[i] == gnt_idx) pos = IW'(i);
        end
        for (int j = 0; j < NT; j++) begin
            if (!any || IW'(j) < pos) order_d[j] = order_q[j];
            else if (j < NT - 1)      order_d[j] = order_q[j + 1];
            else                      order_d[j] = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) order_q[i] <= IW'(i);
        end else begin
            for (int i = 0; i < NT; i++) order_q[i] <= order_d[i];
        end
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r3_mru_update: assert property (@(posedge clk) disable iff (!rst_n)
        any |=> (order_q[NT-1] == $past(gnt_idx)));
    a_r8_normal_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_hi) |-> (|(gnt & req_hi)));
endmodule

// File: rtl/thread_picker.sv
module thread_picker #(
    parameter int NT = 4,
    localparam int IW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] thr_ready,
    input  logic [NT-1:0] ll_hint,
    input  logic [NT-1:0] dep_hint,
    input  logic [NT-1:0] ll_done,
    input  logic [NT-1:0] ld_vld,
    input  logic [NT-1:0] ld_hit,
    input  logic [NT-1:0] fill_done,
    output logic [NT-1:0] issue_gnt,
    output logic [IW-1:0] fetch_tid,
    output logic [NT-1:0] squash,
    output logic          idle
);
    logic [NT-1:0] elig_norm, elig_spec;
    logic          any_gnt;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        tpick_thread u_thr (
            .clk         (clk),
            .rst_n       (rst_n),
            .ready_i     (thr_ready[t]),
            .ll_i        (ll_hint[t]),
            .dep_i       (dep_hint[t]),
            .gnt_i       (issue_gnt[t]),
            .ll_done_i   (ll_done[t]),
            .ld_vld_i    (ld_vld[t]),
            .ld_hit_i    (ld_hit[t]),
            .fill_i      (fill_done[t]),
            .elig_norm_o (elig_norm[t]),
            .elig_spec_o (elig_spec[t]),
            .squash_o    (squash[t])
        );
    end

    tpick_lru #(.NT(NT)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_hi  (elig_norm),
        .req_lo  (elig_spec),
        .gnt     (issue_gnt),
        .gnt_idx (fetch_tid),
        .any     (any_gnt)
    );

    assign idle = ~any_gnt;

    a_r2_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (|(elig_norm | elig_spec)) |-> !idle);
    a_r4_fetch_match: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> issue_gnt[fetch_tid]);
    a_r9_idle_nogrant: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (issue_gnt == '0 && fetch_tid == '0));
endmodule

// File: tb/tb_thread_picker.sv
module tb_thread_picker;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] thr_ready, ll_hint, dep_hint, ll_done, ld_vld, ld_hit, fill_done;
    logic [3:0] issue_gnt, squash;
    logic [1:0] fetch_tid;
    logic       idle;

    int n_chk = 0;
    int n_err = 0;
    int mst [4];
    int mord [4];
    logic [31:0] lf1 = 32'h1ACE_B00C, lf2 = 32'h0BAD_F00D;

    always #10 clk = ~clk;

    thread_picker dut (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .ll_hint(ll_hint),
        .dep_hint(dep_hint), .ll_done(ll_done), .ld_vld(ld_vld), .ld_hit(ld_hit),
        .fill_done(fill_done), .issue_gnt(issue_gnt), .fetch_tid(fetch_tid),
        .squash(squash), .idle(idle)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick(input logic [3:0] rdy, input logic [3:0] dep);
        for (int i = 0; i < 4; i++)
            if (mst[mord[i]] == 0 && rdy[mord[i]] && !dep[mord[i]]) return mord[i];
        for (int i = 0; i < 4; i++)
            if (mst[mord[i]] == 0 && rdy[mord[i]] && dep[mord[i]]) return mord[i];
        return -1;
    endfunction

    task automatic step(input logic [3:0] rdy, ll, dep, lld, vld, hit, fil, input string tag);
        int e;
        logic [3:0] egnt, esq;
        @(negedge clk);
        thr_ready = rdy; ll_hint = ll; dep_hint = dep; ll_done = lld;
        ld_vld = vld; ld_hit = hit; fill_done = fil;
        #2;
        e = pick(rdy, dep);
        egnt = (e < 0) ? 4'd0 : 4'(1 << e);
        for (int t = 0; t < 4; t++) esq[t] = (mst[t] == 2) && vld[t] && !hit[t];
        chk(issue_gnt == egnt, tag, int'(issue_gnt), int'(egnt));
        chk(fetch_tid == ((e < 0) ? 2'd0 : 2'(e)), "R4", int'(fetch_tid), (e < 0) ? 0 : e);
        chk(idle == (e < 0), "R9", int'(idle), int'(e < 0));
        chk(squash == esq, "R7", int'(squash), int'(esq));
        for (int t = 0; t < 4; t++) begin
            case (mst[t])
                0: if (t == e) mst[t] = ll[t] ? 1 : (dep[t] ? 2 : 0);
                1: if (lld[t]) mst[t] = 0;
                2: if (vld[t]) mst[t] = hit[t] ? 0 : 3;
                default: if (fil[t]) mst[t] = 0;
            endcase
        end
        if (e >= 0) begin
            int p = 0;
            for (int i = 0; i < 4; i++) if (mord[i] == e) p = i;
            for (int i = p; i < 3; i++) mord[i] = mord[i + 1];
            mord[3] = e;
        end
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {thr_ready, ll_hint, dep_hint, ll_done, ld_vld, ld_hit, fill_done} = '0;
        for (int t = 0; t < 4; t++) begin mst[t] = 0; mord[t] = t; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset state with nothing ready
        step(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R9");
        // R3 and R2: rotation from reset order, one grant every cycle
        for (int i = 0; i < 8; i++) begin
            step(4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R3");
            chk(issue_gnt == 4'(1 << (i % 4)), "R2", int'(issue_gnt), 1 << (i % 4));
        end
        // R5: thread 0 long-latency, stray done pulse is ignored later
        step(4'hF, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R5");
        for (int i = 0; i < 5; i++) step(4'hF, 4'hF & 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R5");
        step(4'hF, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, "R5");
        step(4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R5");
        // R6: speculative dependent issue on thread 1, load hits
        step(4'h2, 4'h0, 4'h2, 4'h0, 4'h0, 4'h0, 4'h0, "R6");
        step(4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R6");
        step(4'h2, 4'h0, 4'h0, 4'h0, 4'h2, 4'h2, 4'h0, "R6");
        step(4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R6");
        // R7: speculative on thread 2, load misses, fill releases it
        step(4'h4, 4'h0, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0, "R7");
        step(4'h4, 4'h0, 4'h0, 4'h0, 4'h4, 4'h0, 4'h0, "R7");
        for (int i = 0; i < 3; i++) step(4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R7");
        step(4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h4, "R7");
        step(4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R7");
        // R8: speculative candidates lose to normal ones
        for (int i = 0; i < 6; i++) step(4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R8");
        for (int i = 0; i < 4; i++) step(4'hF, 4'h0, 4'hE, 4'h0, 4'h2, 4'h2, 4'h0, "R8");
        // R10: stray pulses on running threads do nothing
        for (int i = 0; i < 6; i++) step(4'hF, 4'h0, 4'h0, 4'hF, 4'hF, 4'h0, 4'hF, "R10");
        // R11: both hints on thread 3: waits for done, later miss no squash
        for (int i = 0; i < 4; i++) step(4'h8, 4'h8, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0, "R11");
        step(4'h8, 4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h0, "R11");
        step(4'h8, 4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 4'h0, "R11");
        step(4'h8, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R11");
        // R1: pseudo-random sweep against the model
        for (int i = 0; i < 3000; i++) begin
            lf1 = {lf1[30:0], lf1[31] ^ lf1[21] ^ lf1[1] ^ lf1[0]};
            lf2 = {lf2[30:0], lf2[31] ^ lf2[21] ^ lf2[1] ^ lf2[0]};
            step(lf1[3:0], lf1[7:4] & lf1[11:8], lf1[15:12] & lf1[19:16],
                 lf1[23:20] & lf2[3:0], lf1[27:24], lf1[31:28], lf2[7:4] & lf2[11:8], "R1");
            chk($countones(issue_gnt) <= 1, "R1", $countones(issue_gnt), 1);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule